// File: doc/BRIEF.md
# Bit-Reversed Counter Pulse Modulator

This block turns a fixed duty word into a one-bit pulse stream whose average over one counter period equals the duty word divided by the period length. A free-running counter is compared against the duty word. Before the compare, the upper bits of the counter are mirrored. This spreads the high time across the period in small pieces instead of one long pulse. The external low-pass filter that follows therefore sees a much higher ripple frequency than plain pulse-width modulation would give it.

The `REV_BITS` parameter sets how many of the counter's top bits are mirrored. The remaining low bits keep their normal order. Each group of 2^(CNT_W-REV_BITS) steps then holds at most one rising and one falling edge, which caps the switching rate for a slow power stage. For example, a 64-step group on a 17.82 MHz step clock keeps edges near 280 kHz.

The counter moves only on cycles where the step enable is high. A new duty word takes effect only at the start of a period, so every full period carries exactly the programmed number of high steps.

Top module: `bitrev_pwm`

## Requirements
- R1: While `rst_ni` is low and directly after it is released, the counter and the active duty are zero and `bit_o` is low. Because of this, the first period after reset produces no high steps, whatever `level_i` holds.
- R2: The counter advances by one, wrapping from 2^CNT_W-1 to 0, only on rising clock edges where `step_i` is high. On edges where `step_i` is low, the counter and `bit_o` keep their values.
- R3: The active duty copies `level_i` only on the edge where `step_i` is high and the counter is at 2^CNT_W-1. A change of `level_i` at any other time has no effect on `bit_o` until the next period begins.
- R4: Over every full period of 2^CNT_W steps, `bit_o` is high on exactly as many steps as the active duty value. A duty of 0 gives no high steps, and a duty of 2^CNT_W-1 gives one low step per period.
- R5: `bit_o` is high when the compare value is below the active duty. The compare value is built from the counter value c. Bit CNT_W-1-k of the compare value equals bit (CNT_W-REV_BITS)+k of c, for k from 0 to REV_BITS-1. Bits below CNT_W-REV_BITS are taken from c unchanged.
- R6: With full mirroring (REV_BITS = CNT_W = 10), a duty of 512 gives high steps on even counter values only. A duty of 256 gives high steps when the counter is a multiple of 4. A duty of 1 gives a high step only at counter 0.
- R7: With partial mirroring (CNT_W = 10, REV_BITS = 4), `bit_o` changes at most once inside each aligned group of 64 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Counter advance enable |
| level_i | input | CNT_W | Requested duty word, adopted at period start |
| bit_o | output | 1 | Modulated output bit |

## Verification
`bit_o` is decoded from registers with no further register stage. It therefore reflects the counter value that was set up by the most recent rising edge. The bench drives and samples on falling edges only. Each sample is compared with the value expected for the step index the bench tracks itself, and that index advances only after a falling edge that was followed by a stepping rising edge.

A duty change is expected to appear on `bit_o` in the step after a wrap, not earlier. To confirm this, the bench alters `level_i` in the middle of each period and checks that the rest of that period follows the old value. During a hold with `step_i` low, every held cycle is compared with the sample taken just before the hold began.

// File: rtl/bitrev_pwm.sv
module bitrev_pwm #(
  parameter int CNT_W    = 10,
  parameter int REV_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             bit_o
);

  localparam int LOW_W = CNT_W - REV_BITS;
  localparam logic [CNT_W-1:0] LAST = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] cmp;
  logic             wrap;

  assign wrap = step_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + ONE;
      if (wrap) level_q <= level_i;
    end
  end

  for (genvar k = 0; k < REV_BITS; k++) begin : g_mirror
    assign cmp[CNT_W-1-k] = cnt_q[LOW_W+k];
  end

  for (genvar j = 0; j < LOW_W; j++) begin : g_keep
    assign cmp[j] = cnt_q[j];
  end

  assign bit_o = (cmp < level_q);

endmodule

module bitrev_pwm_chk #(
  parameter int CNT_W    = 10,
  parameter int REV_BITS = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic [CNT_W-1:0] level_i,
  input logic             bit_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] level_q
);

  localparam logic [CNT_W-1:0] LAST = '1;
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W-1);

  logic [CNT_W:0] hi_q;

  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |-> !bit_o)
    else $error("R1 output high in reset");

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(cnt_q) && $stable(bit_o)))
    else $error("R2 moved without step");

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))))
    else $error("R2 counter did not advance");

  a_r3_keep_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && cnt_q == LAST) |=> $stable(level_q))
    else $error("R3 duty changed mid-period");

  a_r3_adopt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q == LAST) |=> (level_q == $past(level_i)))
    else $error("R3 duty not adopted at wrap");

  a_r4_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == '0) |-> !bit_o)
    else $error("R4 high with zero duty");

  if (REV_BITS == CNT_W) begin : g_full
    a_r6_half_alt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level_q == HALF) |-> (bit_o == !cnt_q[0]))
      else $error("R6 half duty not alternating");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else if (step_i) begin
      if (cnt_q == LAST) begin
        a_r4_period_count: assert ((hi_q + (CNT_W+1)'(bit_o)) == {1'b0, level_q})
          else $error("R4 period high count mismatch");
        hi_q <= '0;
      end else begin
        hi_q <= hi_q + (CNT_W+1)'(bit_o);
      end
    end
  end

endmodule

bind bitrev_pwm bitrev_pwm_chk #(.CNT_W(CNT_W), .REV_BITS(REV_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .level_i(level_i),
  .bit_o(bit_o), .cnt_q(cnt_q), .level_q(level_q)
);

// File: tb/tb_bitrev_pwm.sv
module tb_bitrev_pwm;
  localparam int W = 10;
  localparam int N = 1 << W;

  logic clk = 0;
  logic rst_ni = 0;
  logic step_i = 0;
  logic [W-1:0] level_i = '0;
  logic bit_full, bit_seg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bitrev_pwm #(.CNT_W(W), .REV_BITS(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .level_i(level_i), .bit_o(bit_full));

  bitrev_pwm #(.CNT_W(W), .REV_BITS(4)) dut_seg (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .level_i(level_i), .bit_o(bit_seg));

  function automatic logic expect_bit(int c, int lvl, int rb);
    int low = W - rb;
    int cmp = 0;
    for (int k = 0; k < rb; k++) if ((c >> (low + k)) & 1) cmp |= 1 << (W - 1 - k);
    for (int j = 0; j < low; j++) if ((c >> j) & 1) cmp |= 1 << j;
    return cmp < lvl;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One full period; active duty lvl, level_i switched to nxt at step chg,
  // optional hold of hlen cycles at step hat.
  task automatic run_period(int lvl, int nxt, int chg, int hat, int hlen, string req);
    int hi = 0, seg_tog = 0, bad = 0;
    logic prev_seg = 0;
    for (int i = 0; i < N; i++) begin
      logic ef = expect_bit(i, lvl, W);
      logic es = expect_bit(i, lvl, 4);
      if (bit_full !== ef || bit_seg !== es) begin
        bad++;
        if (bad <= 4) check(0, req, {bit_full, bit_seg}, {ef, es});
      end
      if (bit_full) hi++;
      if (i % 64 == 0) seg_tog = 0;
      else if (bit_seg != prev_seg) seg_tog++;
      if (seg_tog > 1) begin
        check(0, "R7 seg toggles", seg_tog, 1);
        seg_tog = 0;
      end
      prev_seg = bit_seg;
      if (i == chg) level_i = W'(nxt);
      if (i == hat) begin
        logic hf = bit_full, hs = bit_seg;
        step_i = 0;
        for (int h = 0; h < hlen; h++) begin
          @(negedge clk);
          check(bit_full === hf && bit_seg === hs, "R2 hold", {bit_full, bit_seg}, {hf, hs});
        end
        step_i = 1;
      end
      @(negedge clk);
    end
    check(bad == 0, {req, " pattern"}, bad, 0);
    check(hi == lvl, "R4 high count", hi, lvl);
  endtask

  task automatic t_reset;
    rst_ni = 0; step_i = 0; level_i = W'(512);
    repeat (3) @(negedge clk);
    check(bit_full === 1'b0 && bit_seg === 1'b0, "R1 reset low", {bit_full, bit_seg}, 0);
    rst_ni = 1;
    @(negedge clk);
    check(bit_full === 1'b0, "R1 after release", bit_full, 0);
    step_i = 1;
    run_period(0, 512, 500, -1, 0, "R1 first period zero");
  endtask

  task automatic t_half;     run_period(512, 1, 100, -1, 0, "R6 R3 half duty");   endtask
  task automatic t_one;      run_period(1, 256, 300, -1, 0, "R6 duty one");        endtask
  task automatic t_quarter;  run_period(256, 0, 7, -1, 0, "R6 quarter duty");      endtask
  task automatic t_zero;     run_period(0, 1023, 900, -1, 0, "R4 zero duty");      endtask
  task automatic t_full;     run_period(1023, 645, 2, -1, 0, "R4 max duty");       endtask
  task automatic t_hold;     run_period(645, 512, 600, 10, 20, "R2 R5 hold");     endtask
  task automatic t_seg;      run_period(512, 0, 1000, 70, 5, "R5 R7 segments");    endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_half();
    t_one();
    t_quarter();
    t_zero();
    t_full();
    t_hold();
    t_seg();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule